// File: doc/BRIEF.md
# Three-Level Service Watchdog

This block watches a service line that a processor must keep toggling. The line can be driven high, driven low, or left floating. It reaches this block as a 2-bit level code from an external window comparator. While the line sits at one driven level and the supervised reset is not active, a counter advances by one on each clock. Each change between the two driven levels restarts the count. If the count reaches the configured timeout, the block emits a one-clock strobe that is meant to start the reset pulse generator.

Leaving the line floating turns the watchdog off and keeps the count at zero. An active reset status also keeps the count at zero. When both conditions are gone, counting starts on the next clock. The timeout length is set in clock ticks as CLK_HZ × TIMEOUT_MS / 1000. The default is 1.6 s at 50 MHz, and the acceptable window for a real part is 1.0 s to 2.25 s. Level changes are compared clock by clock with no filtering, so a level that lasts a single cycle still counts as service.

Top module: `wdt_tri_watchdog`

## Requirements
- R1: The level code decodes as 2'b10 = driven high, 2'b01 = driven low, and both 2'b00 and 2'b11 = floating.
- R2: Let TICKS = CLK_HZ*TIMEOUT_MS/1000. A qualifying edge is a rising clock edge at which the code is driven, equals the level sampled at the previous edge, and rst_active_i is low. The strobe goes high after the TICKS-th consecutive qualifying edge, and not before.
- R3: The strobe stays high for exactly one clock. The count then restarts from zero, so with a stuck level and no reset the strobe repeats every TICKS cycles.
- R4: An edge at which the sampled driven level differs from the previous sample counts as service and clears the count. This includes a level that is held for only one cycle.
- R5: An edge at which the code is floating clears the count, and no strobe can follow it. The first driven edge after floating counts as a level change.
- R6: While rst_active_i is high, the count is held at zero and no strobe is issued.
- R7: Counting resumes at the first edge after rst_active_i falls, with no new level change needed. If the reset pulse lasts W cycles after each strobe, a stuck level strobes every TICKS+W cycles.
- R8: While rst_n is low and right after it is released, the strobe is low and the previous level reads as floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_code_i | input | 2 | Decoded service-line level (R1 encoding) |
| rst_active_i | input | 1 | High while the supervised reset output is asserted |
| tmo_strobe_o | output | 1 | One-cycle timeout pulse |

## Verification
The strobe is a register output. Inputs sampled at rising edge k therefore show on the strobe after that same edge. The strobe rises after the TICKS-th qualifying edge, which is TICKS+1 edges after a level change and TICKS edges after a reset release. The bench drives inputs on falling edges and updates a behavioural run-length model on rising edges. At every falling edge it compares the design's strobe with the model. Directed checks count falling edges from each stimulus to the exact cycle of the predicted strobe, and also check the cycle just before it. A bench-side reset-pulse emulator measures the TICKS+W repeat spacing.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    typedef enum logic [1:0] {
        LVL_FLOAT = 2'b00,
        LVL_LOW   = 2'b01,
        LVL_HIGH  = 2'b10
    } lvl_e;

    function automatic lvl_e decode_lvl(input logic [1:0] code);
        case (code)
            2'b10:   return LVL_HIGH;
            2'b01:   return LVL_LOW;
            default: return LVL_FLOAT;
        endcase
    endfunction

    function automatic longint unsigned ticks_of(input longint unsigned hz,
                                                 input longint unsigned ms);
        return (hz * ms) / 64'd1000;
    endfunction

endpackage

// File: rtl/wdt_level_track.sv
`timescale 1ns/1ps
module wdt_level_track
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_i,
    output logic       driven_o,
    output logic       kick_o
);

    typedef struct packed {
        lvl_e prev;
    } trk_t;

    trk_t trk_d, trk_q;
    lvl_e cur;

    always_comb begin
        cur       = decode_lvl(code_i);
        driven_o  = (cur != LVL_FLOAT);
        kick_o    = driven_o && (cur != trk_q.prev);
        trk_d     = trk_q;
        trk_d.prev = cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '{prev: LVL_FLOAT};
        else        trk_q <= trk_d;
    end

    // R4
    kick_records_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |=> (trk_q.prev != LVL_FLOAT));

    // R1
    float_not_stored_as_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 2'b11) |=> (trk_q.prev == LVL_FLOAT));

endmodule

// File: rtl/wdt_timeout_count.sv
`timescale 1ns/1ps
module wdt_timeout_count #(
    parameter longint unsigned TICKS = 64'd80_000_000,
    parameter int              CW    = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic strobe_o
);

    localparam logic [CW-1:0] LAST = CW'(TICKS - 64'd1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          strobe;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt    = '0;
            st_d.strobe = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt    = '0;
            st_d.strobe = 1'b1;
        end else begin
            st_d.cnt    = st_q.cnt + 1'b1;
            st_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, strobe: 1'b0};
        else        st_q <= st_d;
    end

    assign strobe_o = st_q.strobe;

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        64'(st_q.cnt) < TICKS);

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe);

    // R3
    restart_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |-> (st_q.cnt == '0));

    // R5
    clear_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cnt == '0 && !st_q.strobe));

endmodule

// File: rtl/wdt_tri_watchdog.sv
`timescale 1ns/1ps
module wdt_tri_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TIMEOUT_MS = 1600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] svc_code_i,
    input  logic       rst_active_i,
    output logic       tmo_strobe_o
);

    localparam longint unsigned TICKS = ticks_of(64'(CLK_HZ), 64'(TIMEOUT_MS));
    localparam int              CW    = (TICKS > 64'd2) ? $clog2(TICKS) : 1;

    logic driven;
    logic kick;
    logic clear;

    wdt_level_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_i   (svc_code_i),
        .driven_o (driven),
        .kick_o   (kick)
    );

    always_comb clear = rst_active_i || !driven || kick;

    wdt_timeout_count #(.TICKS(TICKS), .CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .strobe_o (tmo_strobe_o)
    );

    // R6
    rst_blocks_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active_i |=> !tmo_strobe_o);

    // R5
    float_blocks_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_code_i == 2'b00 || svc_code_i == 2'b11) |=> !tmo_strobe_o);

    // R2
    strobe_needs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_strobe_o) |-> $past(!rst_active_i && svc_code_i != 2'b00 && svc_code_i != 2'b11));

endmodule

// File: tb/sim_wdt_tri_watchdog.sv
`timescale 1ns/1ps
module sim_wdt_tri_watchdog;

    localparam int CLK_HZ = 10_000;
    localparam int TMS    = 3;
    localparam int TICKS  = CLK_HZ * TMS / 1000;   // 30
    localparam int RW     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] code = 2'b00;
    logic       man_rst = 1'b0;
    logic       gen_rst = 1'b0;
    logic       rst_active;
    logic       strobe;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string phase = "R8";

    int  m_run = 0;
    int  m_prev = 0;
    bit  exp_strobe = 1'b0;
    bit  gen_en = 1'b0;
    int  gen_left = 0;

    assign rst_active = man_rst | gen_rst;

    always #2.5 clk = ~clk;

    wdt_tri_watchdog #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMS)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .svc_code_i   (code),
        .rst_active_i (rst_active),
        .tmo_strobe_o (strobe)
    );

    function automatic int lvl_of(input logic [1:0] c);
        if (c == 2'b10) return 2;
        if (c == 2'b01) return 1;
        return 0;
    endfunction

    // behavioural run-length model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_prev = 0; exp_strobe = 1'b0;
        end else begin
            int lv;
            lv = lvl_of(code);
            exp_strobe = 1'b0;
            if (rst_active || lv == 0 || lv != m_prev) m_run = 0;
            else begin
                m_run++;
                if (m_run == TICKS) begin exp_strobe = 1'b1; m_run = 0; end
            end
            m_prev = lv;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle compare and reset-pulse emulation
    always @(negedge clk) begin
        if (rst_n) chk(strobe === exp_strobe, phase, int'(strobe), int'(exp_strobe));
        if (gen_en && gen_left == 0 && exp_strobe) gen_left = RW;
        else if (gen_left > 0) gen_left--;
        gen_rst = (gen_left > 0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog expired R2 actual=%0d expected=%0d", cyc, 20000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic nwait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int gap;
        // R8 reset state
        nwait(3);
        chk(strobe == 1'b0, "R8", int'(strobe), 0);
        rst_n = 1'b1;
        nwait(2);
        chk(strobe == 1'b0, "R8", int'(strobe), 0);

        // R2 first timeout after a level change: TICKS+1 edges
        phase = "R2";
        code = 2'b10;
        nwait(TICKS);
        chk(strobe == 1'b0, "R2", int'(strobe), 0);
        nwait(1);
        chk(strobe == 1'b1, "R2", int'(strobe), 1);

        // R3 single cycle, repeat every TICKS with stuck level
        phase = "R3";
        nwait(1);
        chk(strobe == 1'b0, "R3", int'(strobe), 0);
        nwait(TICKS - 2);
        chk(strobe == 1'b0, "R3", int'(strobe), 0);
        nwait(1);
        chk(strobe == 1'b1, "R3", int'(strobe), 1);

        // R4 toggling service keeps it quiet; single-cycle pulse counts
        phase = "R4";
        for (int k = 0; k < 4; k++) begin
            code = (code == 2'b10) ? 2'b01 : 2'b10;
            nwait(TICKS - 5);
        end
        chk(strobe == 1'b0, "R4", int'(strobe), 0);
        code = 2'b01;
        nwait(20);
        code = 2'b10;
        nwait(1);
        code = 2'b01;
        nwait(TICKS);
        chk(strobe == 1'b0, "R4", int'(strobe), 0);
        nwait(1);
        chk(strobe == 1'b1, "R4", int'(strobe), 1);

        // R1 / R5 code 11 and 00 float: no strobe, count cleared
        phase = "R5";
        code = 2'b11;
        nwait(2 * TICKS);
        chk(strobe == 1'b0, "R1", int'(strobe), 0);
        code = 2'b10;
        nwait(TICKS);
        chk(strobe == 1'b0, "R5", int'(strobe), 0);
        nwait(1);
        chk(strobe == 1'b1, "R5", int'(strobe), 1);
        nwait(25);
        code = 2'b00;
        nwait(1);
        code = 2'b10;
        nwait(TICKS);
        chk(strobe == 1'b0, "R5", int'(strobe), 0);
        nwait(1);
        chk(strobe == 1'b1, "R5", int'(strobe), 1);

        // R6 reset status holds clear; R7 resumes at once after release
        phase = "R6";
        nwait(25);
        man_rst = 1'b1;
        nwait(2 * TICKS);
        chk(strobe == 1'b0, "R6", int'(strobe), 0);
        man_rst = 1'b0;
        phase = "R7";
        nwait(TICKS - 1);
        chk(strobe == 1'b0, "R7", int'(strobe), 0);
        nwait(1);
        chk(strobe == 1'b1, "R7", int'(strobe), 1);

        // R7 repeat spacing with emulated reset pulse of RW cycles
        gen_en = 1'b1;
        nwait(1);
        gap = 0;
        while (strobe !== 1'b1 && gap < 200) begin nwait(1); gap++; end
        gap = 0;
        nwait(1);
        gap = 1;
        while (strobe !== 1'b1 && gap < 200) begin nwait(1); gap++; end
        chk(gap == TICKS + RW, "R7", gap, TICKS + RW);
        gen_en = 1'b0;
        nwait(RW + 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule